// File: doc/BRIEF.md
# Card Bridge Control Register

This block holds the 16-bit bridge control word of a single-socket host-to-card bus bridge. Host configuration software writes and reads the word at configuration offset 3Eh through a simple strobe port with two byte enables. The stored bits drive the controls that the rest of the bridge uses: card reset, write posting, prefetch type for each memory window, and interrupt routing select. The block also turns card-side error events into host-side indications, gated by the matching enable bits.

The block also makes two forwarding decisions. For an I/O address it applies the ISA alias filter and the VGA I/O decode. For a memory address it applies the VGA frame-buffer decode. Two synchronous resets act on the word in different ways. A global reset restores the whole word. A host-bus reset never touches the card-reset bit. The power-management bits are cleared by the host-bus reset only while power management is off.

Top module: `brctl_reg`

## Requirements
- R1: A global reset loads 0340h. Reading at offset 3Eh returns the stored word. Reading at any other offset returns zero.
- R2: Bits 15 to 11 and bit 4 always read as zero, and writes to them are ignored.
- R3: A write at offset 3Eh takes effect at the next clock edge. `cfg_be[0]` gates bits 7 to 0 and `cfg_be[1]` gates bits 15 to 8. A write to any other offset changes nothing.
- R4: `card_rst` is high whenever bit 6 is 1 or `host_rst` is high.
- R5: Bit 6 is cleared only by the global reset. A host-bus reset leaves it unchanged.
- R6: The context bits are all writable bits except bit 6. With `pm_en` low, a host-bus reset returns them to their 0340h values. With `pm_en` high, they hold. Writes are ignored in any cycle where `host_rst` is high.
- R7: `post_en` follows bit 10, `pf_win1` follows bit 9, `pf_win0` follows bit 8, and `irq_legacy` follows bit 7.
- R8: ISA mode is bit 2. When it is set, an I/O address below 10000h whose bits 9:8 are nonzero is not forwarded. Otherwise an I/O address is forwarded when `io_win_hit` is high.
- R9: VGA enable is bit 3. When it is set, any I/O address whose low 10 bits fall in 3B0h–3BBh or 3C0h–3DFh is forwarded. This takes priority over the window hit and over the ISA filter.
- R10: `mem_fwd` is high when `mem_win_hit` is high. It is also high when VGA enable is set and the memory address lies in A0000h–BFFFFh.
- R11: `host_serr` is high when `card_serr` is high and bit 1 is set, or when a reported master abort occurs and `host_serr_en` is high.
- R12: Master-abort mode is bit 5. When it is set, `card_mabort` raises `host_tabort`. When it is clear, master aborts raise neither `host_tabort` nor `host_serr`.
- R13: `perr_report` is high when `card_perr` is high and bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| glob_rst | input | 1 | Global reset, synchronous, active high |
| host_rst | input | 1 | Host-bus reset, synchronous, active high |
| pm_en | input | 1 | Power management enabled |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 2 | Byte enables |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data |
| card_rst | output | 1 | Card reset |
| post_en | output | 1 | Write posting enable |
| pf_win1 | output | 1 | Window 1 prefetchable |
| pf_win0 | output | 1 | Window 0 prefetchable |
| irq_legacy | output | 1 | Route card interrupts by the legacy IRQ setting |
| io_addr | input | AW | Presented I/O address |
| io_win_hit | input | 1 | I/O address falls in an open window |
| io_fwd | output | 1 | Forward I/O access to the card |
| mem_addr | input | AW | Presented memory address |
| mem_win_hit | input | 1 | Memory address falls in an open window |
| mem_fwd | output | 1 | Forward memory access to the card |
| card_serr | input | 1 | Card-side system error |
| host_serr_en | input | 1 | Host SERR reporting enabled |
| host_serr | output | 1 | Host-side system error |
| card_mabort | input | 1 | Master abort seen on the card side |
| host_tabort | output | 1 | Target abort toward the host |
| card_perr | input | 1 | Card-side parity error |
| perr_report | output | 1 | Report parity error |

## Verification
The I/O decode is swept address by address over the first 80K of I/O space, with all four settings of ISA mode and VGA enable. This separates filter blocking, VGA priority, alias matching on the low 10 bits, and the 64K limit of the filter. The memory decode is swept in 2 KB steps past 1 MB, so both edges of the A0000h–BFFFFh range are checked with VGA enable on and off.

Byte-enable writes use complementary data patterns, which exposes lane swaps and writes to reserved bits. Host-bus resets are applied with power management both on and off, with bit 6 set, so the reset domains of bit 6 and of the context bits can be told apart. The error gates are tried in every input combination.

// File: rtl/brctl_reg.sv
module brctl_reg #(
  parameter int          AW       = 32,
  parameter logic [7:0]  REG_OFS  = 8'h3E,
  parameter logic [15:0] RST_VAL  = 16'h0340,
  parameter logic [15:0] WR_MASK  = 16'h07EF,
  parameter logic [15:0] CTX_MASK = 16'h07AF
) (
  input  logic          clk,
  input  logic          glob_rst,
  input  logic          host_rst,
  input  logic          pm_en,
  input  logic [7:0]    cfg_addr,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_be,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  output logic          card_rst,
  output logic          post_en,
  output logic          pf_win1,
  output logic          pf_win0,
  output logic          irq_legacy,
  input  logic [AW-1:0] io_addr,
  input  logic          io_win_hit,
  output logic          io_fwd,
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_win_hit,
  output logic          mem_fwd,
  input  logic          card_serr,
  input  logic          host_serr_en,
  output logic          host_serr,
  input  logic          card_mabort,
  output logic          host_tabort,
  input  logic          card_perr,
  output logic          perr_report
);
  localparam int          CRST_B   = 6;
  localparam logic [15:0] CRST_M   = 16'(1) << CRST_B;
  localparam logic [15:0] HCLR_ALL = WR_MASK & ~CRST_M;
  localparam logic [15:0] HCLR_PM  = HCLR_ALL & ~CTX_MASK;
  localparam logic [AW-1:0] VGA_LO = AW'(20'hA0000);
  localparam logic [AW-1:0] VGA_HI = AW'(20'hC0000);

  logic [15:0] ctl_q;
  logic [15:0] be_mask, host_clr;
  logic        wr_hit;

  assign wr_hit   = cfg_wr && (cfg_addr == REG_OFS);
  assign be_mask  = {{8{cfg_be[1]}}, {8{cfg_be[0]}}} & WR_MASK;
  assign host_clr = pm_en ? HCLR_PM : HCLR_ALL;

  always_ff @(posedge clk) begin
    if (glob_rst)
      ctl_q <= RST_VAL;
    else if (host_rst)
      ctl_q <= (ctl_q & ~host_clr) | (RST_VAL & host_clr);
    else if (wr_hit)
      ctl_q <= (ctl_q & ~be_mask) | (cfg_wdata & be_mask);
  end

  assign cfg_rdata  = (cfg_addr == REG_OFS) ? (ctl_q & WR_MASK) : 16'h0;
  assign card_rst   = ctl_q[CRST_B] | host_rst;
  assign post_en    = ctl_q[10];
  assign pf_win1    = ctl_q[9];
  assign pf_win0    = ctl_q[8];
  assign irq_legacy = ctl_q[7];

  logic [9:0] io_lo;
  logic       io_low64k, isa_blk, vga_io, vga_mem, mab_rep;

  assign io_lo     = io_addr[9:0];
  assign io_low64k = (io_addr[AW-1:16] == '0);
  assign isa_blk   = ctl_q[2] && io_low64k && (io_addr[9:8] != 2'b00);
  assign vga_io    = ctl_q[3] && (((io_lo >= 10'h3B0) && (io_lo <= 10'h3BB)) ||
                                  ((io_lo >= 10'h3C0) && (io_lo <= 10'h3DF)));
  assign io_fwd    = vga_io || (io_win_hit && !isa_blk);
  assign vga_mem   = ctl_q[3] && (mem_addr >= VGA_LO) && (mem_addr < VGA_HI);
  assign mem_fwd   = mem_win_hit || vga_mem;

  assign mab_rep     = card_mabort && ctl_q[5];
  assign host_tabort = mab_rep;
  assign host_serr   = (card_serr && ctl_q[1]) || (mab_rep && host_serr_en);
  assign perr_report = card_perr && ctl_q[0];

  assert_grst_val_R1: assert property (@(posedge clk)
    glob_rst |=> (ctl_q == RST_VAL));

  assert_crst_hold_R5: assert property (@(posedge clk) disable iff (glob_rst)
    host_rst |=> (ctl_q[CRST_B] == $past(ctl_q[CRST_B])));

  assert_ctx_hold_R6: assert property (@(posedge clk) disable iff (glob_rst)
    (host_rst && pm_en) |=> ((ctl_q & CTX_MASK) == $past(ctl_q & CTX_MASK)));

  assert_isa_block_R8: assert property (@(posedge clk)
    (io_fwd && isa_blk) |-> vga_io);

  assert_noabort_R12: assert property (@(posedge clk) disable iff (glob_rst)
    (!ctl_q[5] && host_tabort) |-> 1'b0);

  assert_rsvd_R2: assert property (@(posedge clk) disable iff (glob_rst)
    (cfg_addr == REG_OFS) |-> ((cfg_rdata & ~WR_MASK) == 16'h0));
endmodule

// File: tb/brctl_reg_tb_top.sv
module brctl_reg_tb_top;
  logic clk = 0;
  always #4 clk = ~clk;

  logic glob_rst = 1, host_rst = 0, pm_en = 1;
  logic [7:0] cfg_addr = 8'h3E;
  logic cfg_wr = 0;
  logic [1:0] cfg_be = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic card_rst, post_en, pf_win1, pf_win0, irq_legacy;
  logic [31:0] io_addr = 0, mem_addr = 0;
  logic io_win_hit = 0, io_fwd, mem_win_hit = 0, mem_fwd;
  logic card_serr = 0, host_serr_en = 0, host_serr, card_mabort = 0, host_tabort;
  logic card_perr = 0, perr_report;

  brctl_reg dut_i (.*);

  int checks = 0, errors = 0;
  logic [15:0] model;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [1:0] be, logic [15:0] d);
    logic [15:0] m;
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_addr = 8'h3E;
    m = {{8{be[1]}}, {8{be[0]}}} & 16'h07EF;
    if (a == 8'h3E) model = (model & ~m) | (d & m);
    #1;
  endtask

  task automatic host_pulse(logic pm, logic with_wr);
    @(negedge clk);
    pm_en = pm; host_rst = 1;
    if (with_wr) begin cfg_wr = 1; cfg_be = 2'b11; cfg_wdata = 16'hFFFF; end
    #1 chk("R4 card_rst during host reset", card_rst, 1);
    @(negedge clk);
    host_rst = 0; cfg_wr = 0; pm_en = 1;
    if (!pm) model = (model & ~16'h07AF) | (16'h0340 & 16'h07AF);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    glob_rst = 0; model = 16'h0340;
    #1;
    chk("R1 reset value", cfg_rdata, 16'h0340);
    chk("R4 card_rst after reset", card_rst, 1);
    chk("R7 pf_win outputs at reset", {pf_win1, pf_win0}, 2'b11);
    cfg_addr = 8'h3C; #1;
    chk("R1 other offset reads zero", cfg_rdata, 0);
    cfg_addr = 8'h3E;

    cfg_write(8'h3E, 2'b01, 16'hAAAA); chk("R3 low lane write", cfg_rdata, model);
    cfg_write(8'h3E, 2'b10, 16'h5555); chk("R3 high lane write", cfg_rdata, model);
    cfg_write(8'h3E, 2'b11, 16'hFFFF);
    chk("R2 reserved bits read zero", cfg_rdata, 16'h07EF);
    chk("R7 outputs follow bits", {post_en, pf_win1, pf_win0, irq_legacy}, 4'hF);
    cfg_write(8'h3C, 2'b11, 16'h0000); chk("R3 other offset ignored", cfg_rdata, 16'h07EF);
    cfg_write(8'h3E, 2'b00, 16'h0000); chk("R3 no byte enable", cfg_rdata, 16'h07EF);
    cfg_write(8'h3E, 2'b11, 16'h0000);
    chk("R2 clear all", cfg_rdata, 0);
    chk("R4 card_rst low", card_rst, 0);
    chk("R7 outputs clear", {post_en, pf_win1, pf_win0, irq_legacy}, 4'h0);

    for (int p = 0; p < 4; p++) begin
      cfg_write(8'h3E, 2'b11, (p[0] ? 16'hF7EF : 16'h0810) ^ (p[1] ? 16'h0040 : 16'h0));
      chk("R2 pattern readback", cfg_rdata, model);
      chk("R4 card_rst follows bit6", card_rst, model[6]);
    end

    cfg_write(8'h3E, 2'b11, 16'h04E5);
    host_pulse(1'b1, 1'b0);
    chk("R6 pm on holds context", cfg_rdata, 16'h04E5);
    chk("R5 bit6 kept, pm on", cfg_rdata[6], 1);
    host_pulse(1'b0, 1'b1);
    chk("R6 pm off restores context, write ignored", cfg_rdata, model);
    chk("R5 bit6 kept, pm off", cfg_rdata[6], 1);
    cfg_write(8'h3E, 2'b11, 16'h0000);
    host_pulse(1'b0, 1'b0);
    chk("R5 bit6 stays clear", cfg_rdata[6], 0);
    @(negedge clk); glob_rst = 1; @(negedge clk); glob_rst = 0; model = 16'h0340; #1;
    chk("R1 global reset restores", cfg_rdata, 16'h0340);

    for (int m = 0; m < 4; m++) begin
      cfg_write(8'h3E, 2'b11, {12'h0, m[0], m[1], 2'b00});
      for (int w = 0; w < 2; w++) begin
        io_win_hit = w[0];
        for (int a = 0; a < 32'h14000; a += (w == 0 ? 1 : 3)) begin
          logic vh, bl;
          io_addr = a; #1;
          vh = m[0] && ((a % 1024 >= 'h3B0 && a % 1024 <= 'h3BB) ||
                        (a % 1024 >= 'h3C0 && a % 1024 <= 'h3DF));
          bl = m[1] && a < 65536 && (a % 1024) >= 256;
          if (io_fwd !== (vh || (w[0] && !bl)))
            chk(vh ? "R9 VGA io forward" : "R8 ISA filter", io_fwd, vh || (w[0] && !bl));
          else checks++;
        end
      end
      mem_win_hit = 0;
      for (int a = 0; a < 32'h120000; a += 32'h800) begin
        mem_addr = a; #1;
        chk("R10 VGA memory window", mem_fwd, m[0] && a >= 'hA0000 && a < 'hC0000);
      end
      mem_win_hit = 1; mem_addr = 0; #1;
      chk("R10 window hit forwards", mem_fwd, 1);
      mem_win_hit = 0;
    end

    for (int b = 0; b < 4; b++) begin
      cfg_write(8'h3E, 2'b11, {10'h0, b[1], 3'b000, b[0], b[0]});
      for (int i = 0; i < 16; i++) begin
        card_serr = i[0]; card_mabort = i[1]; host_serr_en = i[2]; card_perr = i[3]; #1;
        chk("R11 host SERR", host_serr, (i[0] && b[0]) || (i[1] && b[1] && i[2]));
        chk("R12 target abort", host_tabort, i[1] && b[1]);
        chk("R13 parity report", perr_report, i[3] && b[0]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule